// File: doc/BRIEF.md
# Fractional Tick Divider with Pin Gating

This block makes the count-enable strobe for a PWM counter. It divides a stream of input events by a fixed-point divisor that has an 8-bit whole part and a 4-bit sixteenths part. The output is a single-cycle `tick` pulse. Over many events, the average tick rate is exactly the event rate divided by the divisor. Any single tick arrives at most one event early or late.

A two-bit source select picks what counts as an event:
- every system clock cycle;
- every cycle in which an external pin is high;
- each rising edge of that pin;
- each falling edge of that pin.

The pin passes through a synchroniser before it is used. The divisor and source select are held in an internal register. Any change to them restarts the phase accumulator, so the first tick after a change is never early.

The strobe is meant to feed the enable input of a counter in the same clock domain. The counter itself, the output stages and the register access are not part of this block.

Top module: `frac_tick_div`

## Requirements
- R1: While `rst_n` is low, `tick` is 0. Reset loads the held configuration with divisor 1.0 and source 0. If the inputs match that default, `tick` is high in every cycle after reset is released.
- R2: The divisor D in sixteenths is 16·`div_int` + `div_frac`. A `div_int` of 0 is treated as D = 16 (divisor 1.0), and `div_frac` is then ignored.
- R3: Let n be the number of events since the last restart. After n events, the number of ticks is floor(16·n / D). A tick appears in the cycle right after the clock edge that takes the event, and never without an event.
- R4: Source 1 (gate) counts one event per clock edge at which the synchronised pin is high. While the pin is low, no events are counted.
- R5: Source 2 counts one event for each low-to-high transition of the synchronised pin.
- R6: Source 3 counts one event for each high-to-low transition of the synchronised pin.
- R7: The pin has two synchroniser stages. A pin level first sampled at clock edge k counts as an event at edge k+2. The resulting tick is visible after edge k+2.
- R8: At a clock edge where any of `div_int`, `div_frac` or `src_mode` differs from the held configuration:
  - no tick is produced;
  - the event count restarts from zero;
  - the new values become the held configuration.
- R9: The phase accumulator always stays below D. In source 0, consecutive ticks are therefore spaced floor(D/16) or ceil(D/16) cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_int | input | 8 | Whole part of the divisor |
| div_frac | input | 4 | Sixteenths part of the divisor |
| src_mode | input | 2 | Event source: 0 clock, 1 pin-high gate, 2 pin rising, 3 pin falling |
| ext_in | input | 1 | Asynchronous external pin |
| tick | output | 1 | Single-cycle count-enable strobe |

## Verification
Source 0 is run with several divisors:
- 1.0 shows that every cycle ticks;
- 1.5 checks the exact average, with 200 ticks in 300 events;
- 3.25 checks the uneven spacing;
- the largest divisor checks accumulator width;
- a zero whole part checks the clamp to 1.0.

The pin-driven sources are fed random pin waveforms. These separate level gating from counting rising or falling edges, because a pin held high produces many gated events but only one edge. A single directed pin step measures the two-stage latency. A fractional-only configuration change made mid-run shows that the restart drops the tick in the change cycle. Random configuration changes then mix all of these.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;

  typedef enum logic [1:0] {
    SRC_FREE = 2'd0,
    SRC_GATE = 2'd1,
    SRC_RISE = 2'd2,
    SRC_FALL = 2'd3
  } src_mode_e;

  // Divisor in sixteenths; a zero whole part falls back to exactly one.
  function automatic int unsigned eff_div(int unsigned whole, int unsigned frac,
                                          int unsigned frac_w);
    if (whole == 0) return (32'd1 << frac_w);
    return (whole << frac_w) | frac;
  endfunction

  // True when one more event carries the phase past the divisor.
  function automatic logic phase_wraps(int unsigned ph, int unsigned step,
                                       int unsigned dv);
    return (ph + step) >= dv;
  endfunction

  function automatic int unsigned phase_next(int unsigned ph, int unsigned step,
                                             int unsigned dv, logic evt);
    int unsigned s;
    if (!evt) return ph;
    s = ph + step;
    return (s >= dv) ? (s - dv) : s;
  endfunction

endpackage

// File: rtl/tickdiv_pin_sync.sv
module tickdiv_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;
endmodule

// File: rtl/tickdiv_cfg_hold.sv
module tickdiv_cfg_hold #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [1:0]        mode_in,
  output logic [INT_W-1:0]  int_q,
  output logic [FRAC_W-1:0] frac_q,
  output logic [1:0]        mode_q,
  output logic              cfg_chg
);
  localparam logic [INT_W-1:0] INT_RST = INT_W'(1);

  assign cfg_chg = (int_in != int_q) || (frac_in != frac_q) || (mode_in != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= INT_RST;
      frac_q <= '0;
      mode_q <= 2'd0;
    end else begin
      int_q  <= int_in;
      frac_q <= frac_in;
      mode_q <= mode_in;
    end
  end
endmodule

// File: rtl/tickdiv_event_sel.sv
module tickdiv_event_sel
  import tickdiv_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       lvl,
  input  logic       rise,
  input  logic       fall,
  output logic       evt
);
  always_comb begin
    unique case (src_mode_e'(mode))
      SRC_FREE: evt = 1'b1;
      SRC_GATE: evt = lvl;
      SRC_RISE: evt = rise;
      SRC_FALL: evt = fall;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/tickdiv_phase_acc.sv
module tickdiv_phase_acc
  import tickdiv_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             evt,
  input  logic [DIV_W-1:0] divisor,
  output logic [DIV_W-1:0] phase,
  output logic             tick
);
  localparam int unsigned STEP = 32'd1 << FRAC_W;

  logic             tick_d;
  logic [DIV_W-1:0] phase_d;

  always_comb begin
    tick_d  = evt & phase_wraps(32'(phase), STEP, 32'(divisor));
    phase_d = DIV_W'(phase_next(32'(phase), STEP, 32'(divisor), evt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tick  <= 1'b0;
    end else if (clr) begin
      phase <= '0;
      tick  <= 1'b0;
    end else begin
      phase <= phase_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import tickdiv_pkg::*;
#(
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic [1:0]        src_mode,
  input  logic              ext_in,
  output logic              tick
);
  localparam int DIV_W = INT_W + FRAC_W;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [1:0]        mode_q;
  logic              cfg_chg;
  logic              b_lvl, b_rise, b_fall;
  logic              evt;
  logic [DIV_W-1:0]  divisor;
  logic [DIV_W-1:0]  phase;

  tickdiv_cfg_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .int_in(div_int), .frac_in(div_frac), .mode_in(src_mode),
    .int_q(int_q), .frac_q(frac_q), .mode_q(mode_q), .cfg_chg(cfg_chg)
  );

  tickdiv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(ext_in),
    .lvl(b_lvl), .rise(b_rise), .fall(b_fall)
  );

  tickdiv_event_sel u_sel (
    .mode(mode_q), .lvl(b_lvl), .rise(b_rise), .fall(b_fall), .evt(evt)
  );

  assign divisor = DIV_W'(eff_div(32'(int_q), 32'(frac_q), FRAC_W));

  tickdiv_phase_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg), .evt(evt),
    .divisor(divisor), .phase(phase), .tick(tick)
  );
endmodule

// File: rtl/frac_tick_div_checker.sv
module frac_tick_div_checker #(
  parameter int DIV_W  = 12,
  parameter int FRAC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             evt,
  input logic             cfg_chg,
  input logic             b_lvl,
  input logic [1:0]       mode_q,
  input logic [DIV_W-1:0] phase,
  input logic [DIV_W-1:0] divisor
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1) << FRAC_W;

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!tick);
  end

  p_phase_below_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase < divisor);

  p_tick_needs_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(evt) && !$past(cfg_chg)));

  p_unity_every_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == ONE && evt && !cfg_chg) |=> tick);

  p_gate_low_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1 && !b_lvl) |-> !evt);

  p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2 && evt) |-> b_lvl);

  p_fall_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3 && evt) |-> !b_lvl);

  p_change_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (phase == '0 && !tick));
endmodule

bind frac_tick_div frac_tick_div_checker #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .cfg_chg(cfg_chg),
  .b_lvl(b_lvl), .mode_q(mode_q), .phase(phase), .divisor(divisor)
);

// File: tb/frac_tick_div_bench.sv
module frac_tick_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_int = 8'd1;
  logic [3:0] div_frac = 4'd0;
  logic [1:0] src_mode = 2'd0;
  logic       ext_in = 1'b0;
  logic       tick;

  always #4 clk = ~clk;

  frac_tick_div u_frac_tick_div (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
    .src_mode(src_mode), .ext_in(ext_in), .tick(tick)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    chk_on = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // Reference model state
  bit         q1, q2, q3;
  bit [7:0]   mi;
  bit [3:0]   mf;
  bit [1:0]   mm;
  longint     n_ev;
  bit         exp_tick;

  function automatic longint ref_div(bit [7:0] i, bit [3:0] f);
    if (i == 0) return 16;
    return longint'(i) * 16 + longint'(f);
  endfunction

  function automatic bit ref_tick(longint n, longint d);
    return ((16 * n) / d) != ((16 * (n - 1)) / d);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 = 0; q2 = 0; q3 = 0;
      mi = 8'd1; mf = 4'd0; mm = 2'd0;
      n_ev = 0; exp_tick = 0;
    end else begin
      bit ev;
      if (div_int != mi || div_frac != mf || src_mode != mm) begin
        mi = div_int; mf = div_frac; mm = src_mode;
        n_ev = 0; exp_tick = 0;
      end else begin
        case (mm)
          2'd0: ev = 1'b1;
          2'd1: ev = q2;
          2'd2: ev = q2 & ~q3;
          default: ev = ~q2 & q3;
        endcase
        if (ev) begin
          n_ev++;
          exp_tick = ref_tick(n_ev, ref_div(mi, mf));
        end else exp_tick = 0;
      end
      q3 = q2; q2 = q1; q1 = ext_in;
    end
  end

  task automatic check(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: tick=%b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) check(cur_req, tick, exp_tick);
  end

  task automatic set_cfg(bit [7:0] i, bit [3:0] f, bit [1:0] m);
    div_int = i; div_frac = f; src_mode = m;
  endtask

  task automatic run(int cycles, int toggle_pct);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (toggle_pct > 0 && ($urandom % 100) < toggle_pct) ext_in = ~ext_in;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    int cnt;
    seed = $urandom(32'd20240917);
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check("R1", tick, 1'b0);
    end
    rst_n = 1'b1;
    chk_on = 1;
    cur_req = "R1";
    run(40, 0);

    // R3: exact average with divisor 1.5
    @(negedge clk); set_cfg(8'd1, 4'd8, 2'd0); cur_req = "R3";
    @(negedge clk);
    cnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      cnt += int'(tick);
    end
    checks++;
    if (cnt != 200) begin
      fails++;
      $display("FAIL R3: ticks=%0d expected 200", cnt);
    end

    // R9: uneven spacing with 3.25, then largest divisor
    set_cfg(8'd3, 4'd4, 2'd0); cur_req = "R9";
    run(200, 0);
    set_cfg(8'd255, 4'd15, 2'd0);
    run(1100, 0);

    // R2: zero whole part clamps to 1.0
    set_cfg(8'd0, 4'd5, 2'd0); cur_req = "R2";
    run(30, 0);

    // R8: fraction-only change mid-run drops the tick
    set_cfg(8'd1, 4'd0, 2'd0); cur_req = "R8";
    run(10, 0);
    set_cfg(8'd1, 4'd1, 2'd0);
    @(negedge clk);
    check("R8", tick, 1'b0);
    run(40, 0);

    // R7: pin latency in rising-edge mode, divisor 1.0
    ext_in = 1'b0;
    set_cfg(8'd1, 4'd0, 2'd2); cur_req = "R7";
    run(8, 0);
    ext_in = 1'b1;
    @(negedge clk); check("R7", tick, 1'b0);
    @(negedge clk); check("R7", tick, 1'b0);
    @(negedge clk); check("R7", tick, 1'b1);
    @(negedge clk); check("R7", tick, 1'b0);

    // R4 gate, R5 rising, R6 falling with random pin waveforms
    set_cfg(8'd2, 4'd3, 2'd1); cur_req = "R4"; run(600, 30);
    set_cfg(8'd1, 4'd0, 2'd1); run(200, 20);
    set_cfg(8'd1, 4'd0, 2'd2); cur_req = "R5"; run(400, 35);
    set_cfg(8'd1, 4'd12, 2'd2); run(600, 35);
    set_cfg(8'd1, 4'd0, 2'd3); cur_req = "R6"; run(400, 35);
    set_cfg(8'd2, 4'd7, 2'd3); run(600, 35);

    // Random configurations mixed with random pin activity
    cur_req = "R3";
    for (int k = 0; k < 60; k++) begin
      bit [7:0] wi;
      wi = (($urandom % 8) == 0) ? 8'($urandom) : 8'($urandom % 5);
      set_cfg(wi, 4'($urandom), 2'($urandom));
      run(50 + int'($urandom % 150), 25);
    end

    chk_on = 0;
    finish_run();
  end
endmodule